// File: doc/BRIEF.md
# Stream to Four-Segment Transmit Bus Packer

This block takes a 128-bit valid/ready byte stream and packs it onto a 512-bit transmit bus that is split into four independent 16-byte segments. Every accepted input beat occupies exactly one segment. The beats are placed in arrival order, starting at segment 0. Each segment carries its own enable, start flag, end flag, empty-byte count, channel number and error flag. A packet therefore always starts on a segment boundary. The next packet may begin in the segment directly after the end of the previous one.

A word leaves the block once all four segments hold a beat. A word also leaves when the source offers nothing for one cycle while at least one segment is filled. The byte-keep mask of the last beat is turned into a count of empty lanes counted down from the top byte. An error on the last beat forces the low three bits of that count to zero. Keep masks that break the stream rules set a sticky protocol-error flag. The block sits between a packet source and a segmented transmit core, and the core applies backpressure through the output ready.

Top module: `seg_stream_packer`

## Requirements
- R1: After reset, m_valid is low, m_ena is all zero, s_ready is high and proto_err is low.
- R2: Each accepted beat appears in exactly one enabled output segment, in arrival order, with its 16 data bytes unchanged (byte 0 on bits [7:0] of the segment). No beat is lost or repeated.
- R3: m_sop is high on the segment that carries the first beat of a packet and low on the segments of later beats. A one-beat packet has m_sop and m_eop high in the same segment.
- R4: m_eop is high exactly on the segment of a beat that had s_last high. There, m_mty equals 16 minus the number of set keep bits (keep contiguous from bit 0; 0 means all 16 bytes are valid). On every other enabled segment m_mty is 0.
- R5: A last beat with s_err high gives m_err high on its segment, with m_mty[2:0] forced to 0 and m_mty[3] kept. s_err on a beat that is not a last beat is ignored, and m_err stays low.
- R6: Every enabled segment carries the s_chan value of its beat on its 8-bit m_chan field.
- R7: While m_valid is high, the enabled segments form a run that starts at segment 0. m_sop, m_eop and m_err are low on segments whose enable is low. When four beats arrive back to back with m_ready high, the word has all four enables set.
- R8: If at least one segment is filled and no beat is offered for one cycle, the partial word is presented with only the filled segments enabled.
- R9: While m_valid is high and m_ready is low, every output field holds steady and s_ready is low when the gathering register cannot take a beat.
- R10: proto_err is set by an accepted non-last beat whose keep is not all ones. It is also set by a last beat whose keep is zero or not contiguous from bit 0. Once set, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat offered |
| s_ready | output | 1 | Input beat can be taken |
| s_data | input | 128 | Input beat bytes, byte 0 in bits [7:0] |
| s_keep | input | 16 | Valid-byte mask of the beat |
| s_last | input | 1 | Beat ends its packet |
| s_chan | input | 8 | Channel number of the packet |
| s_err | input | 1 | Packet is in error (meaningful on the last beat) |
| m_valid | output | 1 | Output word is presented |
| m_ready | input | 1 | Output word is taken |
| m_data | output | 512 | Four 128-bit segments, segment 0 in the low bits |
| m_ena | output | 4 | Per-segment enable |
| m_sop | output | 4 | Per-segment start of packet |
| m_eop | output | 4 | Per-segment end of packet |
| m_mty | output | 16 | Per-segment 4-bit empty-lane count |
| m_chan | output | 32 | Per-segment 8-bit channel |
| m_err | output | 4 | Per-segment packet error |
| proto_err | output | 1 | Sticky stream-rule violation |

## Verification
The hardest situation to create from the ports is a full gathering register held by a low m_ready while another beat is already waiting. In that case the waiting beat must enter segment 0 in the same cycle the held word is taken. To reach it, the stimulus keeps m_ready low while six beats are pushed from a separate thread, and it samples the held word twice during the stall. It then releases m_ready and confirms that a full word and then a two-segment flush word come out with nothing missing or doubled. Flushes on an idle cycle and the error-override cases of the empty count are reached through a table of beats that mixes single-segment, multi-segment and errored packets.

// File: rtl/seg_pack_pkg.sv
package seg_pack_pkg;

  localparam int unsigned DEF_SEGS      = 4;
  localparam int unsigned DEF_SEG_BYTES = 16;
  localparam int unsigned DEF_CHAN_W    = 8;

  // Number of set bits in a keep mask (zero-extended to 64 bits).
  function automatic int unsigned lane_count(input logic [63:0] k);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(k[i]);
    return n;
  endfunction

  // True when the mask is non-empty and its set bits run upward from bit 0.
  function automatic logic low_contig(input logic [63:0] k);
    return (k != 64'd0) && (((k + 64'd1) & k) == 64'd0);
  endfunction

endpackage

// File: rtl/seg_beat_encode.sv
module seg_beat_encode
  import seg_pack_pkg::*;
#(
  parameter int unsigned SEG_BYTES = DEF_SEG_BYTES,
  localparam int unsigned MTY_W    = $clog2(SEG_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [SEG_BYTES-1:0] in_keep,
  input  logic                 in_last,
  input  logic                 in_err,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic [MTY_W-1:0]     out_mty,
  output logic                 out_err,
  output logic                 bad_keep
);

  // Empty lanes from the top; an error keeps only the most significant bit.
  function automatic logic [MTY_W-1:0] empty_lanes(input logic [SEG_BYTES-1:0] k,
                                                   input logic e);
    int                  gap;
    logic [MTY_W-1:0]    m;
    gap = int'(SEG_BYTES) - int'(lane_count(64'(k)));
    m   = MTY_W'(gap);
    if (e) m[MTY_W-2:0] = '0;
    return m;
  endfunction

  logic mid_q;  // a packet is open: the next beat is not a start

  always_ff @(posedge clk) begin
    if (!rst_n)    mid_q <= 1'b0;
    else if (take) mid_q <= !in_last;
  end

  assign out_sop  = !mid_q;
  assign out_eop  = in_last;
  assign out_err  = in_last & in_err;
  assign out_mty  = in_last ? empty_lanes(in_keep, in_err) : '0;
  assign bad_keep = take && (in_last ? !low_contig(64'(in_keep)) : (in_keep != '1));

endmodule

// File: rtl/seg_gather.sv
module seg_gather #(
  parameter int unsigned SEGS   = 4,
  parameter int unsigned SEG_W  = 128,
  parameter int unsigned MTY_W  = 4,
  parameter int unsigned CHAN_W = 8,
  localparam int unsigned CNT_W = $clog2(SEGS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  output logic                     take,
  input  logic [SEG_W-1:0]         w_data,
  input  logic                     w_sop,
  input  logic                     w_eop,
  input  logic [MTY_W-1:0]         w_mty,
  input  logic                     w_err,
  input  logic [CHAN_W-1:0]        w_chan,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic                     fire,
  output logic [SEGS*SEG_W-1:0]    m_data,
  output logic [SEGS-1:0]          m_ena,
  output logic [SEGS-1:0]          m_sop,
  output logic [SEGS-1:0]          m_eop,
  output logic [SEGS*MTY_W-1:0]    m_mty,
  output logic [SEGS*CHAN_W-1:0]   m_chan,
  output logic [SEGS-1:0]          m_err
);

  logic [CNT_W-1:0] cnt_q;    // segments filled
  logic             flush_q;  // idle cycle seen with a partial word

  assign m_valid  = (cnt_q == CNT_W'(SEGS)) | flush_q;
  assign in_ready = !m_valid | m_ready;
  assign take     = in_valid & in_ready;
  assign fire     = m_valid & m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else if (fire) begin
      cnt_q   <= take ? CNT_W'(1) : '0;
      flush_q <= 1'b0;
    end else if (take) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end else if (!m_valid && cnt_q != '0) begin
      flush_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    logic                wr;
    logic [SEG_W-1:0]    d_q;
    logic [MTY_W-1:0]    mty_q;
    logic [CHAN_W-1:0]   chan_q;
    logic                ena_q, sop_q, eop_q, err_q;

    assign wr = take && (fire ? (i == 0) : (cnt_q == CNT_W'(i)));

    always_ff @(posedge clk) begin
      if (!rst_n || (fire && !wr)) begin
        d_q <= '0; mty_q <= '0; chan_q <= '0;
        ena_q <= 1'b0; sop_q <= 1'b0; eop_q <= 1'b0; err_q <= 1'b0;
      end else if (wr) begin
        d_q <= w_data; mty_q <= w_mty; chan_q <= w_chan;
        ena_q <= 1'b1; sop_q <= w_sop; eop_q <= w_eop; err_q <= w_err;
      end
    end

    assign m_data[i*SEG_W +: SEG_W]   = d_q;
    assign m_mty[i*MTY_W +: MTY_W]    = mty_q;
    assign m_chan[i*CHAN_W +: CHAN_W] = chan_q;
    assign m_ena[i] = ena_q;
    assign m_sop[i] = sop_q;
    assign m_eop[i] = eop_q;
    assign m_err[i] = err_q;
  end

endmodule

// File: rtl/seg_sticky_flag.sv
module seg_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end

endmodule

// File: rtl/seg_stream_packer.sv
module seg_stream_packer
  import seg_pack_pkg::*;
#(
  parameter int unsigned SEGS      = DEF_SEGS,
  parameter int unsigned SEG_BYTES = DEF_SEG_BYTES,
  parameter int unsigned CHAN_W    = DEF_CHAN_W,
  localparam int unsigned SEG_W    = 8 * SEG_BYTES,
  localparam int unsigned MTY_W    = $clog2(SEG_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [SEG_W-1:0]       s_data,
  input  logic [SEG_BYTES-1:0]   s_keep,
  input  logic                   s_last,
  input  logic [CHAN_W-1:0]      s_chan,
  input  logic                   s_err,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [SEGS*SEG_W-1:0]  m_data,
  output logic [SEGS-1:0]        m_ena,
  output logic [SEGS-1:0]        m_sop,
  output logic [SEGS-1:0]        m_eop,
  output logic [SEGS*MTY_W-1:0]  m_mty,
  output logic [SEGS*CHAN_W-1:0] m_chan,
  output logic [SEGS-1:0]        m_err,
  output logic                   proto_err
);

  // Named internal events
  logic             beat_taken;
  logic             word_fire;
  logic             keep_violation;
  logic             enc_sop, enc_eop, enc_err;
  logic [MTY_W-1:0] enc_mty;

  seg_beat_encode #(.SEG_BYTES(SEG_BYTES)) enc_i (
    .clk(clk), .rst_n(rst_n), .take(beat_taken),
    .in_keep(s_keep), .in_last(s_last), .in_err(s_err),
    .out_sop(enc_sop), .out_eop(enc_eop), .out_mty(enc_mty),
    .out_err(enc_err), .bad_keep(keep_violation)
  );

  seg_gather #(.SEGS(SEGS), .SEG_W(SEG_W), .MTY_W(MTY_W), .CHAN_W(CHAN_W)) gat_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_valid), .in_ready(s_ready), .take(beat_taken),
    .w_data(s_data), .w_sop(enc_sop), .w_eop(enc_eop), .w_mty(enc_mty),
    .w_err(enc_err), .w_chan(s_chan),
    .m_valid(m_valid), .m_ready(m_ready), .fire(word_fire),
    .m_data(m_data), .m_ena(m_ena), .m_sop(m_sop), .m_eop(m_eop),
    .m_mty(m_mty), .m_chan(m_chan), .m_err(m_err)
  );

  seg_sticky_flag perr_i (
    .clk(clk), .rst_n(rst_n), .set(keep_violation), .flag(proto_err)
  );

endmodule

// File: rtl/seg_stream_packer_chk.sv
module seg_stream_packer_chk #(
  parameter int unsigned SEGS   = 4,
  parameter int unsigned SEG_W  = 128,
  parameter int unsigned MTY_W  = 4,
  parameter int unsigned CHAN_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   s_ready,
  input logic                   m_valid,
  input logic                   m_ready,
  input logic [SEGS*SEG_W-1:0]  m_data,
  input logic [SEGS-1:0]        m_ena,
  input logic [SEGS-1:0]        m_sop,
  input logic [SEGS-1:0]        m_eop,
  input logic [SEGS*MTY_W-1:0]  m_mty,
  input logic [SEGS*CHAN_W-1:0] m_chan,
  input logic [SEGS-1:0]        m_err,
  input logic                   proto_err
);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_ena) &&
                               $stable(m_sop) && $stable(m_eop) && $stable(m_mty) &&
                               $stable(m_chan) && $stable(m_err)));

  a_r9_stall_reason: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> (m_valid && !m_ready));

  a_r7_ena_run: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_ena[0] && ((m_ena & (m_ena + SEGS'(1))) == '0)));

  a_r7_flags_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (((m_sop | m_eop | m_err) & ~m_ena) == '0));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    a_r5_err_mty: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_err[i]) |-> (m_eop[i] && m_mty[i*MTY_W +: MTY_W-1] == '0));
  end

endmodule

bind seg_stream_packer seg_stream_packer_chk #(
  .SEGS(SEGS), .SEG_W(SEG_W), .MTY_W(MTY_W), .CHAN_W(CHAN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_ena(m_ena), .m_sop(m_sop), .m_eop(m_eop), .m_mty(m_mty),
  .m_chan(m_chan), .m_err(m_err), .proto_err(proto_err)
);

// File: tb/seg_stream_packer_tb_top.sv
module seg_stream_packer_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [127:0] s_data = '0;
  logic [15:0]  s_keep = '0;
  logic         s_last = 1'b0;
  logic [7:0]   s_chan = '0;
  logic         s_err = 1'b0;
  logic         m_valid;
  logic         m_ready = 1'b1;
  logic [511:0] m_data;
  logic [3:0]   m_ena, m_sop, m_eop, m_err;
  logic [15:0]  m_mty;
  logic [31:0]  m_chan;
  logic         proto_err;

  always #2 clk = ~clk;  // 250 MHz

  seg_stream_packer dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_keep(s_keep), .s_last(s_last), .s_chan(s_chan), .s_err(s_err),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_ena(m_ena),
    .m_sop(m_sop), .m_eop(m_eop), .m_mty(m_mty), .m_chan(m_chan), .m_err(m_err),
    .proto_err(proto_err)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input logic [159:0] act,
                     input logic [159:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Segment record: {data, sop, eop, mty, err, chan} = 143 bits
  logic [159:0] exp_seg [0:63];
  logic [159:0] got_seg [0:63];
  logic [3:0]   got_word [0:31];
  int ne = 0, ng = 0, nw = 0;

  function automatic logic [127:0] mk_data(input int tag);
    logic [127:0] d;
    for (int j = 0; j < 16; j++) d[j*8 +: 8] = 8'(tag * 7 + j * 3 + 1);
    return d;
  endfunction

  always @(negedge clk) begin
    if (m_valid && m_ready) begin
      if (nw < 32) got_word[nw] = m_ena;
      nw++;
      for (int i = 0; i < 4; i++)
        if (m_ena[i] && ng < 64) begin
          got_seg[ng] = {17'd0, m_data[i*128 +: 128], m_sop[i], m_eop[i],
                         m_mty[i*4 +: 4], m_err[i], m_chan[i*8 +: 8]};
          ng++;
        end
    end
  end

  task automatic send(input logic [15:0] k, input logic l, input logic e,
                      input logic [7:0] ch, input int tag);
    @(negedge clk);
    s_valid = 1'b1; s_keep = k; s_last = l; s_err = e; s_chan = ch;
    s_data = mk_data(tag);
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic go_idle(input int cycles);
    @(negedge clk);
    s_valid = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic push_exp(input int tag, input logic sp, input logic ep,
                          input logic [3:0] mt, input logic er, input logic [7:0] ch);
    exp_seg[ne] = {17'd0, mk_data(tag), sp, ep, mt, er, ch};
    ne++;
  endtask

  task automatic clear_logs();
    ne = 0; ng = 0; nw = 0;
  endtask

  task automatic cmp_segs(input string req);
    chk(ng == ne, req, 160'(ng), 160'(ne));
    for (int i = 0; i < ne && i < ng; i++)
      chk(got_seg[i] == exp_seg[i], req, got_seg[i], exp_seg[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  typedef struct packed {
    logic [15:0] keep;
    logic        last;
    logic        err;
    logic [7:0]  chan;
    logic        xsop;
    logic        xeop;
    logic [3:0]  xmty;
    logic        xerr;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{16'hFFFF, 1'b1, 1'b0, 8'h03, 1'b1, 1'b1, 4'd0,  1'b0},  // R3 one-beat packet
    '{16'hFFFF, 1'b0, 1'b0, 8'h05, 1'b1, 1'b0, 4'd0,  1'b0},  // R3 start
    '{16'hFFFF, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 4'd0,  1'b0},  // R3 middle
    '{16'h0007, 1'b1, 1'b0, 8'h05, 1'b0, 1'b1, 4'd13, 1'b0},  // R4 3 bytes
    '{16'h00FF, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 4'd8,  1'b1},  // R5 bit3 kept
    '{16'h0FFF, 1'b1, 1'b1, 8'h02, 1'b1, 1'b1, 4'd0,  1'b1},  // R5 4 -> 0
    '{16'h0001, 1'b1, 1'b0, 8'h07, 1'b1, 1'b1, 4'd15, 1'b0},  // R4 one byte
    '{16'hFFFF, 1'b0, 1'b1, 8'h04, 1'b1, 1'b0, 4'd0,  1'b0},  // R5 non-last err ignored
    '{16'h7FFF, 1'b1, 1'b0, 8'h04, 1'b0, 1'b1, 4'd1,  1'b0},  // R4 top lane empty
    '{16'h3FFF, 1'b1, 1'b0, 8'h09, 1'b1, 1'b1, 4'd2,  1'b0},  // R4
    '{16'hFFFF, 1'b0, 1'b0, 8'h06, 1'b1, 1'b0, 4'd0,  1'b0},  // R6
    '{16'h01FF, 1'b1, 1'b1, 8'h06, 1'b0, 1'b1, 4'd0,  1'b1}   // R5 7 -> 0
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  logic [511:0] held;

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk(m_valid == 1'b0, "R1 m_valid", 160'(m_valid), 160'(0));
    chk(m_ena == 4'd0, "R1 m_ena", 160'(m_ena), 160'(0));
    chk(s_ready == 1'b1, "R1 s_ready", 160'(s_ready), 160'(1));
    chk(proto_err == 1'b0, "R1 proto_err", 160'(proto_err), 160'(0));

    // Table of beats, sent back to back: R2 R3 R4 R5 R6 R7
    clear_logs();
    for (int v = 0; v < 12; v++) begin
      push_exp(v, VEC[v].xsop, VEC[v].xeop, VEC[v].xmty, VEC[v].xerr, VEC[v].chan);
      send(VEC[v].keep, VEC[v].last, VEC[v].err, VEC[v].chan, v);
    end
    go_idle(6);
    cmp_segs("R2/R3/R4/R5/R6 table");
    chk(nw == 3, "R7 word count", 160'(nw), 160'(3));
    for (int w = 0; w < 3 && w < nw; w++)
      chk(got_word[w] == 4'hF, "R7 full word", 160'(got_word[w]), 160'(4'hF));
    chk(proto_err == 1'b0, "R10 clean stream", 160'(proto_err), 160'(0));

    // R8 idle flush after two beats
    clear_logs();
    push_exp(40, 1'b1, 1'b0, 4'd0, 1'b0, 8'h11);
    push_exp(41, 1'b0, 1'b1, 4'd6, 1'b0, 8'h11);
    send(16'hFFFF, 1'b0, 1'b0, 8'h11, 40);
    send(16'h03FF, 1'b1, 1'b0, 8'h11, 41);
    go_idle(6);
    chk(nw == 1, "R8 flush word count", 160'(nw), 160'(1));
    chk(got_word[0] == 4'b0011, "R8 partial enables", 160'(got_word[0]), 160'(4'b0011));
    cmp_segs("R8 flush segments");

    // R9 backpressure: six beats against a stalled output
    clear_logs();
    @(posedge clk); #1 m_ready = 1'b0;
    for (int b = 0; b < 6; b++)
      push_exp(50 + b, b == 0, b == 5, b == 5 ? 4'd4 : 4'd0, 1'b0, 8'h22);
    fork
      begin
        for (int b = 0; b < 6; b++)
          send(b == 5 ? 16'h0FFF : 16'hFFFF, b == 5, 1'b0, 8'h22, 50 + b);
        go_idle(8);
      end
      begin
        repeat (7) @(negedge clk);
        held = m_data;
        repeat (4) @(negedge clk);
        #1;
        chk(s_ready == 1'b0, "R9 s_ready low", 160'(s_ready), 160'(0));
        chk(m_valid == 1'b1, "R9 m_valid held", 160'(m_valid), 160'(1));
        chk(m_data == held, "R9 data stable", 160'(m_data), 160'(held));
        chk(nw == 0, "R9 nothing taken", 160'(nw), 160'(0));
        @(posedge clk); #1 m_ready = 1'b1;
      end
    join
    chk(nw == 2, "R9 word count", 160'(nw), 160'(2));
    chk(got_word[0] == 4'hF, "R9 first word", 160'(got_word[0]), 160'(4'hF));
    chk(got_word[1] == 4'b0011, "R9 second word", 160'(got_word[1]), 160'(4'b0011));
    cmp_segs("R9 no loss");

    // R10 partial keep on a non-last beat
    send(16'h00FF, 1'b0, 1'b0, 8'h01, 60);
    send(16'hFFFF, 1'b1, 1'b0, 8'h01, 61);
    go_idle(4);
    chk(proto_err == 1'b1, "R10 partial non-last", 160'(proto_err), 160'(1));
    send(16'hFFFF, 1'b1, 1'b0, 8'h01, 62);
    go_idle(4);
    chk(proto_err == 1'b1, "R10 sticky", 160'(proto_err), 160'(1));
    do_reset();
    #1;
    chk(proto_err == 1'b0, "R10 cleared by reset", 160'(proto_err), 160'(0));
    send(16'h0F0F, 1'b1, 1'b0, 8'h01, 63);
    go_idle(4);
    chk(proto_err == 1'b1, "R10 non-contiguous last", 160'(proto_err), 160'(1));

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule